// File: doc/BRIEF.md
# Triple-Buffer Frame Swap Controller

This controller decides buffer ownership for a video path in which a producer (writer) and a consumer (reader) share three frame stores and run at unrelated frame rates. At every moment the writer owns one store, the reader owns another, and the third is held in reserve. The controller takes a one-cycle frame-complete pulse from each side. It answers with a one-cycle start grant and the index of the store that side must use next.

The writer never discards a frame. When it completes a frame while the reserve store still holds a picture the reader has not yet shown, it is held off (`wr_stall`) until the reader takes that picture. The reader never waits. When it completes a frame and a new picture is available in the reserve store, it swaps to that store. Otherwise it shows its current store again and flags the repeat. When both sides complete in the same cycle, the read side is settled first, so a held writer can be released in the very cycle the reader takes the reserve store.

Top module: `tribuf_swap_ctrl`

## Requirements
- R1: While `rst_n` is low, `wr_idx` is 0, `rd_idx` is 1, and `wr_start`, `rd_start`, `rd_repeat` and `wr_stall` are 0. Store 2 is the reserve store and holds no new picture.
- R2: In the first clock after `rst_n` rises, the controller registers `wr_start`=1, `rd_start`=1 and `rd_repeat`=1. Done pulses sampled in that clock are ignored.
- R3: `wr_idx` and `rd_idx` are always distinct, and each is in the range 0..2.
- R4: A sampled `rd_done` while the reserve store holds a new picture gives, one cycle later, `rd_idx` equal to the former reserve index, `rd_start`=1 and `rd_repeat`=0. `rd_idx` changes at no other time.
- R5: A sampled `rd_done` while the reserve store holds no new picture gives, one cycle later, `rd_start`=1 and `rd_repeat`=1, with `rd_idx` unchanged. `rd_repeat` is never 1 without `rd_start`.
- R6: A sampled `wr_done` while the reserve store holds no new picture gives, one cycle later, `wr_start`=1 with `wr_idx` equal to the former reserve index. The store just written becomes the reserve store and is marked as new.
- R7: A sampled `wr_done` while the reserve store holds a new picture gives `wr_stall`=1 and no `wr_start`. `wr_idx` stays unchanged until a `rd_done` is sampled. Further `wr_done` pulses during the stall have no effect.
- R8: When `rd_done` and a pending write hand-off (a new `wr_done` or a stall) are sampled in the same cycle, the read swap of R4/R5 is applied first. The write check of R6/R7 then uses the reserve store left after it, so a stalled writer receives `wr_start` in the same cycle as the reader's `rd_start`.
- R9: Every completed write frame is shown at least once, and frames are shown in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_done | input | 1 | Writer finished its current frame (one-cycle pulse) |
| rd_done | input | 1 | Reader finished its current frame (one-cycle pulse) |
| wr_idx | output | 2 | Store index the writer must fill |
| rd_idx | output | 2 | Store index the reader must display |
| wr_start | output | 1 | Grant for the writer to begin the next frame |
| rd_start | output | 1 | Grant for the reader to begin the next frame |
| rd_repeat | output | 1 | The granted read frame repeats the previous picture |
| wr_stall | output | 1 | Writer is held until the reserve picture has been shown |

## Verification
The hardest case to reach from the ports is a `rd_done` that arrives in the same cycle as a write hand-off while the reserve store already holds a new picture. This is the only path on which the read-first ordering decides whether the writer is released. The bench first runs randomly timed frames, with the writer usually faster than the reader so that stalls build up. It then forces equal, fixed frame lengths for both sides, which makes the done pulses coincide repeatedly. A cycle-accurate ownership model, built on a per-store table rather than index arithmetic, predicts every output. A picture-tag tracker checks that the reader neither skips a frame nor goes backward.

// File: rtl/tribuf_pkg.sv
package tribuf_pkg;
  localparam int unsigned NUM_BUF = 3;
  localparam int unsigned IDX_W   = $clog2(NUM_BUF + 1);

  typedef logic [IDX_W-1:0] buf_idx_t;

  localparam buf_idx_t RST_WR_IDX = buf_idx_t'(0);
  localparam buf_idx_t RST_RD_IDX = buf_idx_t'(1);

  // The three legal indices 0,1,2 XOR to 3, so the unused one is 3^a^b.
  function automatic buf_idx_t idle_of(input buf_idx_t a, input buf_idx_t b);
    return buf_idx_t'(3) ^ a ^ b;
  endfunction

  typedef struct packed {
    logic     fire;
    logic     take;
    logic     rpt;
    buf_idx_t nxt;
  } rd_dec_t;

  typedef struct packed {
    logic     grant;
    logic     hold;
    buf_idx_t nxt;
  } wr_dec_t;
endpackage

// File: rtl/tribuf_read_arb.sv
module tribuf_read_arb
  import tribuf_pkg::*;
(
  input  logic     en,
  input  logic     rd_done,
  input  logic     fresh,
  input  buf_idx_t cur_rd,
  input  buf_idx_t reserve,
  output rd_dec_t  dec
);
  always_comb begin
    dec.fire = en && rd_done;
    dec.take = dec.fire && fresh;
    dec.rpt  = dec.fire && !fresh;
    dec.nxt  = dec.take ? reserve : cur_rd;
  end
endmodule

// File: rtl/tribuf_write_arb.sv
module tribuf_write_arb
  import tribuf_pkg::*;
(
  input  logic     en,
  input  logic     wr_done,
  input  logic     waiting,
  input  logic     fresh_mid,
  input  buf_idx_t cur_wr,
  input  buf_idx_t rd_after,
  output wr_dec_t  dec
);
  logic     pending;
  buf_idx_t reserve_mid;

  always_comb begin
    pending     = en && (waiting || wr_done);
    reserve_mid = idle_of(cur_wr, rd_after);
    dec.grant   = pending && !fresh_mid;
    dec.hold    = pending && fresh_mid;
    dec.nxt     = dec.grant ? reserve_mid : cur_wr;
  end
endmodule

// File: rtl/tribuf_swap_ctrl.sv
module tribuf_swap_ctrl
  import tribuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_done,
  input  logic             rd_done,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_start,
  output logic             rd_start,
  output logic             rd_repeat,
  output logic             wr_stall
);
  buf_idx_t wr_q, rd_q;
  logic     started;
  logic     spare_fresh;
  logic     stall_q;
  logic     wr_start_q, rd_start_q, rpt_q;

  buf_idx_t reserve_now;
  logic     fresh_mid;
  logic     fresh_nxt;
  rd_dec_t  rdec;
  wr_dec_t  wdec;

  assign reserve_now = idle_of(wr_q, rd_q);

  tribuf_read_arb u_rd_arb (
    .en      (started),
    .rd_done (rd_done),
    .fresh   (spare_fresh),
    .cur_rd  (rd_q),
    .reserve (reserve_now),
    .dec     (rdec)
  );

  // The read side is settled first; the write check sees its result.
  assign fresh_mid = spare_fresh && !rdec.take;

  tribuf_write_arb u_wr_arb (
    .en        (started),
    .wr_done   (wr_done),
    .waiting   (stall_q),
    .fresh_mid (fresh_mid),
    .cur_wr    (wr_q),
    .rd_after  (rdec.nxt),
    .dec       (wdec)
  );

  assign fresh_nxt = wdec.grant ? 1'b1 : fresh_mid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q        <= RST_WR_IDX;
      rd_q        <= RST_RD_IDX;
      started     <= 1'b0;
      spare_fresh <= 1'b0;
      stall_q     <= 1'b0;
      wr_start_q  <= 1'b0;
      rd_start_q  <= 1'b0;
      rpt_q       <= 1'b0;
    end else if (!started) begin
      started     <= 1'b1;
      wr_start_q  <= 1'b1;
      rd_start_q  <= 1'b1;
      rpt_q       <= 1'b1;
    end else begin
      rd_q        <= rdec.nxt;
      wr_q        <= wdec.nxt;
      spare_fresh <= fresh_nxt;
      stall_q     <= wdec.hold;
      wr_start_q  <= wdec.grant;
      rd_start_q  <= rdec.fire;
      rpt_q       <= rdec.rpt;
    end
  end

  assign wr_idx    = wr_q;
  assign rd_idx    = rd_q;
  assign wr_start  = wr_start_q;
  assign rd_start  = rd_start_q;
  assign rd_repeat = rpt_q;
  assign wr_stall  = stall_q;
endmodule

// File: rtl/tribuf_swap_ctrl_chk.sv
module tribuf_swap_ctrl_chk
  import tribuf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_done,
  input logic             rd_done,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] rd_idx,
  input logic             wr_start,
  input logic             rd_start,
  input logic             rd_repeat,
  input logic             wr_stall,
  input logic             started,
  input logic             spare_fresh
);
  assert_idx_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx != rd_idx) && (wr_idx != 2'd3) && (rd_idx != 2'd3));

  assert_repeat_needs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_repeat |-> rd_start);

  assert_rd_done_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (started && rd_done) |=> rd_start);

  assert_rd_idx_moves_on_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx != $past(rd_idx)) |-> (rd_start && !rd_repeat));

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stall && !rd_done) |=> (!wr_start && $stable(wr_idx) && wr_stall));

  assert_free_write_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (started && wr_done && !wr_stall && !spare_fresh) |=> (wr_start && !wr_stall));

  assert_stall_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stall && rd_done && spare_fresh) |=> (wr_start && rd_start && !rd_repeat));
endmodule

bind tribuf_swap_ctrl tribuf_swap_ctrl_chk u_chk (.*);

// File: tb/tribuf_swap_ctrl_bench.sv
module tribuf_swap_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_done = 1'b0;
  logic       rd_done = 1'b0;
  logic [1:0] wr_idx, rd_idx;
  logic       wr_start, rd_start, rd_repeat, wr_stall;

  always #(CLK_PERIOD/2) clk = ~clk;

  tribuf_swap_ctrl u_tribuf_swap_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .rd_done(rd_done),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .wr_start(wr_start), .rd_start(rd_start),
    .rd_repeat(rd_repeat), .wr_stall(wr_stall)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // reference model: explicit owner table per store
  int  m_wr, m_rd;
  bit  m_fresh, m_wait, m_started;
  bit  e_ws, e_rs, e_rep;
  int  content[3];
  int  next_id, last_shown;
  bit  w_active, r_active;
  int  w_cnt, r_cnt;
  int  w_lo, w_hi, r_lo, r_hi;
  int  coinc, releases;

  function automatic int unused_store(input int a, input int b);
    for (int k = 0; k < 3; k++)
      if (k != a && k != b) return k;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(input bit wd, input bit rdn);
    e_ws = 0; e_rs = 0; e_rep = 0;
    if (!m_started) begin
      m_started = 1; e_ws = 1; e_rs = 1; e_rep = 1;
      return;
    end
    if (rdn) begin
      e_rs = 1;
      if (m_fresh) begin
        m_rd = unused_store(m_wr, m_rd);
        m_fresh = 0;
      end else e_rep = 1;
    end
    if (m_wait || wd) begin
      if (!m_fresh) begin
        if (m_wait) releases++;
        m_wr = unused_store(m_wr, m_rd);
        m_fresh = 1; m_wait = 0; e_ws = 1;
      end else m_wait = 1;
    end
  endtask

  task automatic check_outputs();
    check(int'(wr_idx) == m_wr, "R6", "wr_idx", int'(wr_idx), m_wr);
    check(int'(rd_idx) == m_rd, "R4", "rd_idx", int'(rd_idx), m_rd);
    check(wr_start == e_ws, "R6", "wr_start", wr_start, e_ws);
    check(rd_start == e_rs, "R5", "rd_start", rd_start, e_rs);
    check(rd_repeat == e_rep, "R5", "rd_repeat", rd_repeat, e_rep);
    check(wr_stall == m_wait, "R7", "wr_stall", wr_stall, m_wait);
    check(wr_idx != rd_idx && wr_idx != 2'd3 && rd_idx != 2'd3, "R3",
          "index collision", int'(wr_idx), int'(rd_idx));
  endtask

  task automatic do_reset();
    wr_done = 0; rd_done = 0;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    check(wr_idx == 2'd0, "R1", "reset wr_idx", int'(wr_idx), 0);
    check(rd_idx == 2'd1, "R1", "reset rd_idx", int'(rd_idx), 1);
    check({wr_start, rd_start, rd_repeat, wr_stall} == 4'b0, "R1", "reset flags",
          int'({wr_start, rd_start, rd_repeat, wr_stall}), 0);
    m_wr = 0; m_rd = 1; m_fresh = 0; m_wait = 0; m_started = 0;
    for (int k = 0; k < 3; k++) content[k] = -1;
    last_shown = -1; next_id = 0;
    w_active = 0; r_active = 0;
    rst_n = 1;
    // a done pulse in the boot cycle must be ignored (R2)
    wr_done = 1; rd_done = 1;
    model_step(0, 0);
  endtask

  task automatic step();
    bit wd, rdn;
    @(negedge clk);
    check_outputs();
    if (wr_start) begin
      w_active = 1;
      w_cnt = int'($urandom_range(w_hi, w_lo));
    end
    if (rd_start) begin
      int id;
      id = content[m_rd];
      if (e_rep && e_rs && !m_started) ;
      if (id >= 0) begin
        if (rd_repeat)
          check(id == last_shown, "R9", "repeated tag", id, last_shown);
        else
          check(id == last_shown + 1, "R9", "shown tag order", id, last_shown + 1);
        last_shown = id;
      end
      r_active = 1;
      r_cnt = int'($urandom_range(r_hi, r_lo));
    end
    wd = 0; rdn = 0;
    if (w_active) begin
      if (w_cnt == 0) begin
        wd = 1; w_active = 0;
        content[m_wr] = next_id; next_id++;
      end else w_cnt--;
    end else if (wr_stall && ($urandom_range(3, 0) == 0)) begin
      wd = 1; // stray pulse during stall, must be ignored (R7)
    end
    if (r_active) begin
      if (r_cnt == 0) begin rdn = 1; r_active = 0; end
      else r_cnt--;
    end
    if (rdn && (wd || m_wait)) coinc++;
    model_step(wd, rdn);
    wr_done = wd; rd_done = rdn;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    coinc = 0; releases = 0;
    w_lo = 1; w_hi = 8; r_lo = 1; r_hi = 11;
    do_reset();
    // R2: boot grants appear after the first clock with reset released
    @(negedge clk);
    check(wr_start && rd_start && rd_repeat, "R2", "boot grants",
          int'({wr_start, rd_start, rd_repeat}), 7);
    check(wr_idx == 2'd0 && rd_idx == 2'd1 && !wr_stall, "R2", "boot ignores dones",
          int'({wr_idx, rd_idx}), 1);
    wr_done = 0; rd_done = 0;
    m_started = 1; e_ws = 0; e_rs = 0; e_rep = 0;
    w_active = 1; w_cnt = 2; r_active = 1; r_cnt = 5;
    for (int i = 0; i < 20000; i++) step();
    // writer much faster: stalls accumulate (R7)
    w_lo = 0; w_hi = 1; r_lo = 4; r_hi = 9;
    for (int i = 0; i < 20000; i++) step();
    // reader much faster: repeats dominate (R5)
    w_lo = 6; w_hi = 14; r_lo = 0; r_hi = 2;
    for (int i = 0; i < 20000; i++) step();
    // directed: equal fixed lengths so dones coincide (R8)
    do_reset();
    @(negedge clk);
    wr_done = 0; rd_done = 0;
    m_started = 1; e_ws = 0; e_rs = 0; e_rep = 0;
    w_lo = 3; w_hi = 3; r_lo = 3; r_hi = 3;
    w_active = 1; w_cnt = 3; r_active = 1; r_cnt = 3;
    for (int i = 0; i < 3000; i++) step();
    check(coinc > 0, "R8", "coincident done pulses seen", coinc, 1);
    check(releases > 0, "R7", "stall releases seen", releases, 1);
    check(last_shown >= next_id - 3, "R9", "written frames reached display",
          last_shown, next_id - 3);
    @(negedge clk);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule